// File: doc/BRIEF.md
# USB Control Endpoint Setup Tracker

This block sits beside the packet engine of a USB device controller and follows the setup packets that reach the control endpoint. A host that loses the device's ACK handshake sends the same setup again. The device can then hold more than one setup request at the same time. The tracker records each completed setup in a small ring of buffer slots. It moves a pointer to the newest slot, so every earlier request is superseded. It then raises interrupt flags that software services and clears by writing one to them.

While a control request is being serviced, software polls two status bits before it moves to the data or status stage:

- The setup-busy bit shows that a new setup is arriving.
- The packet-busy bit shows that any packet is arriving.

Either bit warns that the request in hand may be replaced. To finish a request that has no data stage, software sets the arm bit, which queues a zero-length IN. If the request failed, software sets the stall bit instead. The next setup completion drops both bits, because that request takes over.

Top module: `setup_tracker`

## Requirements
- R1: After a synchronous reset, every output is 0. This covers both interrupt flags, both status bits, arm, stall and the valid index.
- R2: A cycle with `setup_done_i` high sets `setup_irq_o` in the next cycle.
- R3: A `setup_done_i` that arrives while `setup_irq_o` is already 1 sets `multi_irq_o` in the next cycle.
- R4: A cycle with `clr_we_i` high clears `setup_irq_o` when bit 0 of `clr_bits_i` is 1, and clears `multi_irq_o` when bit 1 is 1. A bit written as 0 leaves its flag unchanged, and so does any value written while `clr_we_i` is low.
- R5: When a clear and a `setup_done_i` fall in the same cycle, the setting of each flag takes priority over its clear.
- R6: `sip_o` goes to 1 in the cycle after `setup_start_i`. It returns to 0 in the cycle after `setup_done_i` or `pkt_end_i`. If a start and an end fall in the same cycle, the start takes priority.
- R7: `pip_o` goes to 1 in the cycle after `pkt_start_i`. It returns to 0 in the cycle after `pkt_end_i` or `setup_done_i`. If a start and an end fall in the same cycle, the start takes priority.
- R8: Each `setup_done_i` moves `valid_idx_o` to the next slot, wrapping from DEPTH-1 to 0. The index does not move at any other time.
- R9: `arm_o` goes to 1 after `arm_set_i`. It goes to 0 after `in_done_i` or `setup_done_i`, and either clear takes priority over a set in the same cycle.
- R10: `stall_o` goes to 1 after `stall_set_i`. It goes to 0 after `setup_done_i`, and that clear takes priority over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_start_i | input | 1 | Pulse: setup packet reception began |
| setup_done_i | input | 1 | Pulse: setup received and ACK sent |
| pkt_start_i | input | 1 | Pulse: reception of any packet began |
| pkt_end_i | input | 1 | Pulse: reception ended without a completed setup |
| in_done_i | input | 1 | Pulse: armed zero-length IN was sent |
| clr_we_i | input | 1 | Write strobe for the flag clear |
| clr_bits_i | input | 2 | Write-one-to-clear: bit 0 clears setup, bit 1 clears multi |
| arm_set_i | input | 1 | Software sets the arm bit |
| stall_set_i | input | 1 | Software sets the stall bit |
| setup_irq_o | output | 1 | Setup received interrupt flag |
| multi_irq_o | output | 1 | More than one setup awaits service |
| sip_o | output | 1 | Setup reception in progress |
| pip_o | output | 1 | Packet reception in progress |
| valid_idx_o | output | $clog2(DEPTH) | Slot holding the newest valid setup |
| arm_o | output | 1 | Zero-length IN armed |
| stall_o | output | 1 | Control endpoint stalled |

## Verification
Three collisions matter here:

- **Clear against arrival.** A software clear of both flags can land in the same cycle as a setup completion. The bench forces this with one directed cycle in which the clear strobe with both bits set coincides with `setup_done_i`. It then expects both flags to read 1.
- **Arm or stall against a new setup.** The bench pulses `arm_set_i` and `stall_set_i` together with `setup_done_i` and expects both bits to read 0.
- **Random overlap.** A long random phase overlaps all pulses freely. A behavioural model, compared on every clock, judges each of these cases.

// File: rtl/stk_pkg.sv
package stk_pkg;
  // Bit positions inside the write-one-to-clear word.
  localparam int CLR_SETUP = 0;
  localparam int CLR_MULTI = 1;
  localparam int CLR_W     = 2;

  typedef struct packed {
    logic setup;
    logic multi;
  } irq_flags_t;
endpackage

// File: rtl/stk_irq_flags.sv
module stk_irq_flags
  import stk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             setup_done,
  input  logic             clr_we,
  input  logic [CLR_W-1:0] clr_bits,
  output irq_flags_t       flags
);
  logic clr_setup, clr_multi;
  assign clr_setup = clr_we & clr_bits[CLR_SETUP];
  assign clr_multi = clr_we & clr_bits[CLR_MULTI];

  // Set has priority over clear: a colliding arrival is never lost.
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
    end else begin
      flags.setup <= setup_done | (flags.setup & ~clr_setup);
      flags.multi <= (setup_done & flags.setup) | (flags.multi & ~clr_multi);
    end
  end

  AST_SETUP_RAISE: assert property (@(posedge clk) disable iff (rst)
    setup_done |=> flags.setup); // R2
  AST_MULTI_RAISE: assert property (@(posedge clk) disable iff (rst)
    (setup_done && flags.setup) |=> flags.multi); // R3
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (clr_setup && !setup_done) |=> !flags.setup); // R4
  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (flags.multi && !clr_multi) |=> flags.multi); // R4
  AST_CLASH_SET: assert property (@(posedge clk) disable iff (rst)
    (clr_setup && setup_done) |=> flags.setup); // R5
endmodule

// File: rtl/stk_status.sv
module stk_status (
  input  logic clk,
  input  logic rst,
  input  logic setup_start,
  input  logic setup_done,
  input  logic pkt_start,
  input  logic pkt_end,
  output logic sip,
  output logic pip
);
  logic rx_over;
  assign rx_over = setup_done | pkt_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      sip <= 1'b0;
      pip <= 1'b0;
    end else begin
      sip <= setup_start | (sip & ~rx_over);
      pip <= pkt_start   | (pip & ~rx_over);
    end
  end

  AST_SIP_RISE: assert property (@(posedge clk) disable iff (rst)
    setup_start |=> sip); // R6
  AST_SIP_FALL: assert property (@(posedge clk) disable iff (rst)
    (rx_over && !setup_start) |=> !sip); // R6
  AST_PIP_RISE: assert property (@(posedge clk) disable iff (rst)
    pkt_start |=> pip); // R7
  AST_PIP_FALL: assert property (@(posedge clk) disable iff (rst)
    (rx_over && !pkt_start) |=> !pip); // R7
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int DEPTH = 2,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            setup_done,
  output logic [IDXW-1:0] valid_idx
);
  localparam logic [IDXW-1:0] LAST = IDXW'(DEPTH - 1);

  // Each completion fills the slot after the current valid one, which then
  // becomes the only valid slot; earlier setups are superseded.
  always_ff @(posedge clk) begin
    if (rst)             valid_idx <= '0;
    else if (setup_done) valid_idx <= (valid_idx == LAST) ? '0 : valid_idx + 1'b1;
  end

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !setup_done |=> $stable(valid_idx)); // R8
  AST_IDX_MOVE: assert property (@(posedge clk) disable iff (rst)
    setup_done |=> valid_idx != $past(valid_idx)); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    valid_idx <= LAST); // R8
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic setup_done,
  input  logic in_done,
  input  logic arm_set,
  input  logic stall_set,
  output logic arm,
  output logic stall
);
  always_ff @(posedge clk) begin
    if (rst) begin
      arm   <= 1'b0;
      stall <= 1'b0;
    end else begin
      arm   <= ~(setup_done | in_done) & (arm_set | arm);
      stall <= ~setup_done & (stall_set | stall);
    end
  end

  AST_ARM_DROP: assert property (@(posedge clk) disable iff (rst)
    (setup_done || in_done) |=> !arm); // R9
  AST_ARM_SET: assert property (@(posedge clk) disable iff (rst)
    (arm_set && !setup_done && !in_done) |=> arm); // R9
  AST_STALL_DROP: assert property (@(posedge clk) disable iff (rst)
    setup_done |=> !stall); // R10
  AST_STALL_SET: assert property (@(posedge clk) disable iff (rst)
    (stall_set && !setup_done) |=> stall); // R10
endmodule

// File: rtl/setup_tracker.sv
module setup_tracker
  import stk_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             setup_start_i,
  input  logic             setup_done_i,
  input  logic             pkt_start_i,
  input  logic             pkt_end_i,
  input  logic             in_done_i,
  input  logic             clr_we_i,
  input  logic [CLR_W-1:0] clr_bits_i,
  input  logic             arm_set_i,
  input  logic             stall_set_i,
  output logic             setup_irq_o,
  output logic             multi_irq_o,
  output logic             sip_o,
  output logic             pip_o,
  output logic [IDXW-1:0]  valid_idx_o,
  output logic             arm_o,
  output logic             stall_o
);
  irq_flags_t flags;

  stk_irq_flags u_flags (
    .clk(clk), .rst(rst), .setup_done(setup_done_i),
    .clr_we(clr_we_i), .clr_bits(clr_bits_i), .flags(flags)
  );

  stk_status u_status (
    .clk(clk), .rst(rst), .setup_start(setup_start_i), .setup_done(setup_done_i),
    .pkt_start(pkt_start_i), .pkt_end(pkt_end_i), .sip(sip_o), .pip(pip_o)
  );

  stk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst), .setup_done(setup_done_i), .valid_idx(valid_idx_o)
  );

  stk_ctrl u_ctrl (
    .clk(clk), .rst(rst), .setup_done(setup_done_i), .in_done(in_done_i),
    .arm_set(arm_set_i), .stall_set(stall_set_i), .arm(arm_o), .stall(stall_o)
  );

  assign setup_irq_o = flags.setup;
  assign multi_irq_o = flags.multi;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !(setup_irq_o || multi_irq_o || sip_o || pip_o || arm_o || stall_o)); // R1
endmodule

// File: tb/sim_setup_tracker.sv
module sim_setup_tracker;
  localparam int DEPTH = 2;
  localparam int IDXW  = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic setup_start_i = 0, setup_done_i = 0, pkt_start_i = 0, pkt_end_i = 0;
  logic in_done_i = 0, clr_we_i = 0, arm_set_i = 0, stall_set_i = 0;
  logic [1:0] clr_bits_i = '0;
  logic setup_irq_o, multi_irq_o, sip_o, pip_o, arm_o, stall_o;
  logic [IDXW-1:0] valid_idx_o;

  always #2.5 clk = ~clk; // 200 MHz

  setup_tracker #(.DEPTH(DEPTH)) u0 (.*);

  int checks = 0, failures = 0, cycles = 0;
  // Behavioural reference state
  int m_setup, m_multi, m_sip, m_pip, m_idx, m_arm, m_stall;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic model_step();
    int ns, nm, done, cs, cm;
    if (rst) begin
      m_setup = 0; m_multi = 0; m_sip = 0; m_pip = 0; m_idx = 0; m_arm = 0; m_stall = 0;
      return;
    end
    done = setup_done_i;
    cs = clr_we_i && clr_bits_i[0];
    cm = clr_we_i && clr_bits_i[1];
    ns = (done || (m_setup && !cs)) ? 1 : 0;
    nm = ((done && m_setup) || (m_multi && !cm)) ? 1 : 0;
    m_multi = nm; m_setup = ns;
    if (setup_start_i) m_sip = 1; else if (done || pkt_end_i) m_sip = 0;
    if (pkt_start_i) m_pip = 1; else if (done || pkt_end_i) m_pip = 0;
    if (done) m_idx = (m_idx + 1) % DEPTH;
    if (done || in_done_i) m_arm = 0; else if (arm_set_i) m_arm = 1;
    if (done) m_stall = 0; else if (stall_set_i) m_stall = 1;
  endtask

  task automatic compare_all();
    chk("R2 setup flag", setup_irq_o, m_setup);
    chk("R3 multi flag", multi_irq_o, m_multi);
    chk("R6 sip", sip_o, m_sip);
    chk("R7 pip", pip_o, m_pip);
    chk("R8 valid index", valid_idx_o, m_idx);
    chk("R9 arm", arm_o, m_arm);
    chk("R10 stall", stall_o, m_stall);
  endtask

  // One clock: inputs already driven, model follows the edge, compare at negedge.
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cycles++;
    compare_all();
    setup_start_i = 0; setup_done_i = 0; pkt_start_i = 0; pkt_end_i = 0;
    in_done_i = 0; clr_we_i = 0; clr_bits_i = '0; arm_set_i = 0; stall_set_i = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk);
    rst = 1; tick(); tick();
    rst = 0;
    // R1: everything quiet after reset
    chk("R1 reset outputs", {setup_irq_o, multi_irq_o, sip_o, pip_o, arm_o, stall_o}, 0);
    chk("R1 reset index", valid_idx_o, 0);

    pkt_start_i = 1; setup_start_i = 1; tick();
    chk("R6 sip during setup", sip_o, 1);
    tick();
    setup_done_i = 1; tick();
    chk("R2 setup flag after done", setup_irq_o, 1);
    chk("R8 index moved to slot 1", valid_idx_o, 1);

    // R4: zero bits and strobe-less writes do nothing
    clr_we_i = 1; clr_bits_i = 2'b00; tick();
    chk("R4 zero write keeps flag", setup_irq_o, 1);
    clr_we_i = 0; clr_bits_i = 2'b11; tick();
    chk("R4 no strobe keeps flag", setup_irq_o, 1);

    // Retried setup before service
    pkt_start_i = 1; setup_start_i = 1; tick();
    setup_done_i = 1; tick();
    chk("R3 duplicate raises multi", multi_irq_o, 1);
    chk("R8 index wrapped to 0", valid_idx_o, 0);

    clr_we_i = 1; clr_bits_i = 2'b11; tick();
    chk("R4 clear both", {setup_irq_o, multi_irq_o}, 0);

    // R5: clear colliding with new arrival
    setup_done_i = 1; tick();
    clr_we_i = 1; clr_bits_i = 2'b11; setup_done_i = 1; tick();
    chk("R5 setup survives clash", setup_irq_o, 1);
    chk("R5 multi survives clash", multi_irq_o, 1);

    // R9 / R10
    arm_set_i = 1; tick();
    chk("R9 arm set", arm_o, 1);
    in_done_i = 1; tick();
    chk("R9 arm cleared by IN", arm_o, 0);
    arm_set_i = 1; stall_set_i = 1; setup_done_i = 1; tick();
    chk("R9 setup beats arm set", arm_o, 0);
    chk("R10 setup beats stall set", stall_o, 0);
    stall_set_i = 1; tick();
    chk("R10 stall set", stall_o, 1);
    setup_done_i = 1; tick();
    chk("R10 stall cleared by setup", stall_o, 0);

    // R6/R7: start beats end in the same cycle
    pkt_start_i = 1; setup_start_i = 1; pkt_end_i = 1; tick();
    chk("R6 start wins", sip_o, 1);
    chk("R7 start wins", pip_o, 1);
    pkt_end_i = 1; tick();
    chk("R7 pip ends", pip_o, 0);

    // Random overlap of every pulse
    for (int i = 0; i < 3000; i++) begin
      setup_start_i = ($urandom % 6) == 0;
      setup_done_i  = ($urandom % 7) == 0;
      pkt_start_i   = ($urandom % 5) == 0;
      pkt_end_i     = ($urandom % 6) == 0;
      in_done_i     = ($urandom % 9) == 0;
      clr_we_i      = ($urandom % 4) == 0;
      clr_bits_i    = 2'($urandom);
      arm_set_i     = ($urandom % 8) == 0;
      stall_set_i   = ($urandom % 8) == 0;
      rst           = ($urandom % 500) == 0;
      tick();
      rst = 0;
    end
    finish_run();
  end
endmodule